// File: doc/BRIEF.md
# MSI Event Queue Router

This block accepts decoded inbound message-signalled interrupt writes, one per cycle, and files each one as a 64-byte record in one of several circular event queues kept in system memory. Each request brings an address-width flag, a requester ID, a length, the full write address and two data halfwords. The low data halfword is the MSI number. That number selects an entry in a mapping table. The entry says whether the MSI is routed, which queue it targets, and whether a previous record for it is still waiting for software.

An accepted request produces a single memory write one cycle later, at the target queue's tail slot, and the tail then advances. Software manages the table and the queues through a flat register port. It can program mappings, release the per-MSI inhibit, enable or disable queues, recover a queue that overflowed, and move the head and tail indices. Each queue drives a level interrupt while it is active and holds unconsumed records.

Top module: `msiq_router`

## Requirements
- R1: After reset every queue reads idle (state 1), head and tail are 0, the overflow flag is clear, every mapping is invalid with inhibit clear, no memory write is issued and every interrupt line is low.
- R2: The register address is `{kind[2:0], index[7:0]}`. The kinds are 0 mapping, 1 MSI release, 2 queue control-set, 3 queue control-clear, 4 queue state, 5 tail, and 6 head. A mapping entry holds valid at bit 63, inhibit at bit 62 and the queue number in bits 5:0. Writes store these fields and reads return them, with all other bits zero.
- R3: An accepted request causes exactly one memory write, with mw_valid high in the cycle after the request. The write address is QUEUE_BASE + queue×2^20 + tail×8192.
- R4: Word 0 of the record sits in data bits 63:0. Its fields are: bit 63 zero; bits 62:59 the type (0xB for a 32-bit MSI, 0xF for a 64-bit MSI); bits 58:56 zero; bits 55:46 the length; bits 45:32 address bits 15:2; bits 31:16 the requester ID; bits 15:0 the MSI number.
- R5: Word 1 sits in data bits 127:64 and holds address bits 63:16 above the second data halfword. Data bits 511:128 are zero.
- R6: A request is dropped, with no memory write and no change to any queue or mapping, when any of these holds: the MSI number is at least NUM_MSI, the mapping is invalid, the inhibit bit is set, the queue number is at least NUM_EQ, or the target queue is not active.
- R7: An accepted request sets its MSI's inhibit bit. A write to the release register with bit 62 set clears that bit. A release write without bit 62 has no effect.
- R8: The tail advances by one for each record written and wraps from 127 to 0.
- R9: When advancing the tail would make it equal the head, the record is discarded. The overflow flag (tail register bit 57) is set and the queue enters the error state (4). A control-clear write with bit 57 set clears the flag.
- R10: Queue state is one-hot: 1 idle, 2 active, 4 error. A control-set write with bit 44 moves idle to active. A control-clear write with bit 44 moves active to idle. A control-clear write with bit 47 moves error to idle.
- R11: A queue's interrupt line is high exactly while the queue is active and its head differs from its tail.
- R12: Writes to the head and tail registers load bits 6:0 as the new index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_valid | input | 1 | Request present this cycle |
| msi_is64 | input | 1 | Request used a 64-bit address |
| msi_rid | input | 16 | Requester ID |
| msi_len | input | 10 | Request length |
| msi_addr | input | 64 | Write address of the request |
| msi_data0 | input | 16 | Low data halfword (MSI number) |
| msi_data1 | input | 16 | Second data halfword |
| mw_valid | output | 1 | Memory write strobe |
| mw_addr | output | 64 | Memory write address |
| mw_data | output | 512 | 64-byte record |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_IDX_W+3 | Register kind and index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| eq_irq | output | NUM_EQ | Per-queue interrupt level |

## Verification
The assertions assume that software never writes a queue's control, head or tail register in the same cycle that a request lands on that queue. They also assume it never writes the mapping or release register of the MSI that is being accepted in that cycle. Under these assumptions, the order in which the two sources update shared state does not matter. The stimulus keeps every register access and every request in separate cycles, so it stays within these assumptions. Queue indices are preloaded through the tail and head registers to reach the wrap and overflow boundaries without filling whole rings.

// File: rtl/msiq_pkg.sv
package msiq_pkg;
  localparam int QIDX_W     = 7;   // 128 slots per queue
  localparam int SLOT_SHIFT = 13;  // 8 KB between slots
  localparam int Q_SHIFT    = QIDX_W + SLOT_SHIFT;
  localparam int QNUM_W     = 6;

  localparam int MAP_VALID_BIT = 63;
  localparam int MAP_INH_BIT   = 62;
  localparam int CTL_EN_BIT    = 44;
  localparam int CTL_E2I_BIT   = 47;
  localparam int OVF_BIT       = 57;

  localparam logic [3:0] TYPE_MSI32 = 4'hB;
  localparam logic [3:0] TYPE_MSI64 = 4'hF;

  typedef enum logic [2:0] {
    EQ_IDLE   = 3'b001,
    EQ_ACTIVE = 3'b010,
    EQ_ERROR  = 3'b100
  } eq_state_e;

  typedef enum logic [2:0] {
    RK_MAP    = 3'd0,
    RK_MSICLR = 3'd1,
    RK_CSET   = 3'd2,
    RK_CCLR   = 3'd3,
    RK_STATE  = 3'd4,
    RK_TAIL   = 3'd5,
    RK_HEAD   = 3'd6
  } reg_kind_e;

  function automatic logic [63:0] entry_word0(input logic is64, input logic [9:0] len,
                                              input logic [63:0] addr, input logic [15:0] rid,
                                              input logic [15:0] data0);
    entry_word0 = {1'b0, (is64 ? TYPE_MSI64 : TYPE_MSI32), 3'b000, len, addr[15:2], rid, data0};
  endfunction

  function automatic logic [63:0] entry_word1(input logic [63:0] addr, input logic [15:0] data1);
    entry_word1 = {addr[63:16], data1};
  endfunction

  function automatic logic [63:0] slot_addr(input logic [63:0] base, input logic [QNUM_W-1:0] q,
                                            input logic [QIDX_W-1:0] slot);
    slot_addr = base + ({{(64-QNUM_W){1'b0}}, q} << Q_SHIFT)
                     + ({{(64-QIDX_W){1'b0}}, slot} << SLOT_SHIFT);
  endfunction

  function automatic logic [QIDX_W-1:0] next_slot(input logic [QIDX_W-1:0] s);
    next_slot = s + 1'b1;
  endfunction
endpackage

// File: rtl/msiq_map_table.sv
module msiq_map_table #(
  parameter int NUM_MSI = 32,
  localparam int MSI_W  = $clog2(NUM_MSI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MSI_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic             lk_inh,
  output logic [5:0]       lk_q,
  input  logic             set_inh,
  input  logic [MSI_W-1:0] sw_idx,
  input  logic             map_we,
  input  logic             map_v,
  input  logic             map_i,
  input  logic [5:0]       map_q,
  input  logic             clr_we,
  output logic [63:0]      rd_word
);
  logic [NUM_MSI-1:0] v_q;
  logic [NUM_MSI-1:0] inh_q;
  logic [5:0]         q_q [NUM_MSI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      inh_q <= '0;
      for (int e = 0; e < NUM_MSI; e++) q_q[e] <= '0;
    end else begin
      for (int e = 0; e < NUM_MSI; e++) begin
        if (set_inh && lk_idx == MSI_W'(e)) inh_q[e] <= 1'b1;
        if (map_we && sw_idx == MSI_W'(e)) begin
          v_q[e]   <= map_v;
          inh_q[e] <= map_i;
          q_q[e]   <= map_q;
        end
        if (clr_we && sw_idx == MSI_W'(e)) inh_q[e] <= 1'b0;
      end
    end
  end

  assign lk_valid = v_q[lk_idx];
  assign lk_inh   = inh_q[lk_idx];
  assign lk_q     = q_q[lk_idx];
  assign rd_word  = {v_q[sw_idx], inh_q[sw_idx], 56'b0, q_q[sw_idx]};
endmodule

// File: rtl/msiq_ring.sv
module msiq_ring
  import msiq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              set_en,
  input  logic              clr_dis,
  input  logic              clr_e2i,
  input  logic              clr_ovf,
  input  logic              head_we,
  input  logic              tail_we,
  input  logic [QIDX_W-1:0] wr_idx,
  output eq_state_e         state_o,
  output logic [QIDX_W-1:0] head_o,
  output logic [QIDX_W-1:0] tail_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              push_ok,
  output logic              push_full
);
  logic full;
  logic is_active;

  assign is_active = (state_o == EQ_ACTIVE);
  assign full      = (next_slot(tail_o) == head_o);
  assign push_ok   = push && is_active && !full;
  assign push_full = push && is_active && full;
  assign irq_o     = is_active && (head_o != tail_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= EQ_IDLE;
      head_o  <= '0;
      tail_o  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (push_ok) tail_o <= next_slot(tail_o);
      if (push_full) begin
        ovf_o   <= 1'b1;
        state_o <= EQ_ERROR;
      end
      if (set_en && state_o == EQ_IDLE) state_o <= EQ_ACTIVE;
      if (clr_dis && state_o == EQ_ACTIVE) state_o <= EQ_IDLE;
      if (clr_e2i && state_o == EQ_ERROR) state_o <= EQ_IDLE;
      if (clr_ovf) ovf_o <= 1'b0;
      if (head_we) head_o <= wr_idx;
      if (tail_we) tail_o <= wr_idx;
    end
  end

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_o) == 1); // R10
  AST_OVF_TO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    push_full && !clr_e2i && !clr_ovf |=> state_o == EQ_ERROR && ovf_o); // R9
  AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok && !tail_we |=> tail_o == $past(tail_o) + 7'd1); // R8
endmodule

// File: rtl/msiq_router.sv
module msiq_router
  import msiq_pkg::*;
#(
  parameter int          NUM_MSI    = 32,
  parameter int          NUM_EQ     = 4,
  parameter int          REG_IDX_W  = 8,
  parameter logic [63:0] QUEUE_BASE = 64'h0000_0100_0000_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   msi_valid,
  input  logic                   msi_is64,
  input  logic [15:0]            msi_rid,
  input  logic [9:0]             msi_len,
  input  logic [63:0]            msi_addr,
  input  logic [15:0]            msi_data0,
  input  logic [15:0]            msi_data1,
  output logic                   mw_valid,
  output logic [63:0]            mw_addr,
  output logic [511:0]           mw_data,
  input  logic                   reg_we,
  input  logic [REG_IDX_W+2:0]   reg_addr,
  input  logic [63:0]            reg_wdata,
  output logic [63:0]            reg_rdata,
  output logic [NUM_EQ-1:0]      eq_irq
);
  localparam int MSI_W = $clog2(NUM_MSI);
  localparam int EQ_W  = $clog2(NUM_EQ);

  reg_kind_e              reg_kind;
  logic [REG_IDX_W-1:0]   reg_idx;
  logic                   idx_msi_ok, idx_eq_ok;
  logic [EQ_W-1:0]        rq;

  logic                   lk_valid, lk_inh;
  logic [5:0]             lk_q;
  logic [EQ_W-1:0]        q_sel;
  logic                   msi_in_range, q_in_range, q_active, route, fire;
  logic [63:0]            map_rd;

  eq_state_e              st_w  [NUM_EQ];
  logic [QIDX_W-1:0]      hd_w  [NUM_EQ];
  logic [QIDX_W-1:0]      tl_w  [NUM_EQ];
  logic [NUM_EQ-1:0]      ovf_v, push_ok_v, push_full_v;
  logic                   unused_in;

  assign reg_kind   = reg_kind_e'(reg_addr[REG_IDX_W+2:REG_IDX_W]);
  assign reg_idx    = reg_addr[REG_IDX_W-1:0];
  assign idx_msi_ok = reg_idx < REG_IDX_W'(NUM_MSI);
  assign idx_eq_ok  = reg_idx < REG_IDX_W'(NUM_EQ);
  assign rq         = reg_idx[EQ_W-1:0];
  assign unused_in  = ^{reg_wdata, msi_addr, push_full_v};

  msiq_map_table #(.NUM_MSI(NUM_MSI)) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (msi_data0[MSI_W-1:0]),
    .lk_valid (lk_valid),
    .lk_inh   (lk_inh),
    .lk_q     (lk_q),
    .set_inh  (fire),
    .sw_idx   (reg_idx[MSI_W-1:0]),
    .map_we   (reg_we && reg_kind == RK_MAP && idx_msi_ok),
    .map_v    (reg_wdata[MAP_VALID_BIT]),
    .map_i    (reg_wdata[MAP_INH_BIT]),
    .map_q    (reg_wdata[5:0]),
    .clr_we   (reg_we && reg_kind == RK_MSICLR && idx_msi_ok && reg_wdata[MAP_INH_BIT]),
    .rd_word  (map_rd)
  );

  assign msi_in_range = msi_data0 < 16'(NUM_MSI);
  assign q_in_range   = lk_q < 6'(NUM_EQ);
  assign q_sel        = lk_q[EQ_W-1:0];
  assign q_active     = q_in_range && (st_w[q_sel] == EQ_ACTIVE);
  assign route        = msi_valid && msi_in_range && lk_valid && !lk_inh && q_active;
  assign fire         = |push_ok_v;

  for (genvar e = 0; e < NUM_EQ; e++) begin : g_ring
    logic sel_sw;
    assign sel_sw = reg_we && idx_eq_ok && rq == EQ_W'(e);
    msiq_ring ring_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (route && q_sel == EQ_W'(e)),
      .set_en    (sel_sw && reg_kind == RK_CSET && reg_wdata[CTL_EN_BIT]),
      .clr_dis   (sel_sw && reg_kind == RK_CCLR && reg_wdata[CTL_EN_BIT]),
      .clr_e2i   (sel_sw && reg_kind == RK_CCLR && reg_wdata[CTL_E2I_BIT]),
      .clr_ovf   (sel_sw && reg_kind == RK_CCLR && reg_wdata[OVF_BIT]),
      .head_we   (sel_sw && reg_kind == RK_HEAD),
      .tail_we   (sel_sw && reg_kind == RK_TAIL),
      .wr_idx    (reg_wdata[QIDX_W-1:0]),
      .state_o   (st_w[e]),
      .head_o    (hd_w[e]),
      .tail_o    (tl_w[e]),
      .ovf_o     (ovf_v[e]),
      .irq_o     (eq_irq[e]),
      .push_ok   (push_ok_v[e]),
      .push_full (push_full_v[e])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
    end else begin
      mw_valid <= fire;
      if (fire) begin
        mw_addr <= slot_addr(QUEUE_BASE, lk_q, tl_w[q_sel]);
        mw_data <= {384'b0, entry_word1(msi_addr, msi_data1),
                    entry_word0(msi_is64, msi_len, msi_addr, msi_rid, msi_data0)};
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_kind)
      RK_MAP:   if (idx_msi_ok) reg_rdata = map_rd;
      RK_STATE: if (idx_eq_ok)  reg_rdata = {61'b0, st_w[rq]};
      RK_TAIL:  if (idx_eq_ok)  reg_rdata = {6'b0, ovf_v[rq], 50'b0, tl_w[rq]};
      RK_HEAD:  if (idx_eq_ok)  reg_rdata = {57'b0, hd_w[rq]};
      default:  reg_rdata = '0;
    endcase
  end

  AST_WRITE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> $past(msi_valid)); // R3
  AST_ONE_RING_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(push_ok_v) <= 1); // R3
  AST_INHIBIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid && lk_inh |=> !mw_valid); // R6
  AST_INACTIVE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid && !q_active |=> !mw_valid); // R6
endmodule

// File: tb/msiq_router_tb.sv
module msiq_router_tb_top;
  localparam int          NM   = 32;
  localparam int          NQ   = 4;
  localparam logic [63:0] BASE = 64'h0000_0100_0000_0000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         msi_valid, msi_is64;
  logic [15:0]  msi_rid, msi_data0, msi_data1;
  logic [9:0]   msi_len;
  logic [63:0]  msi_addr;
  logic         mw_valid;
  logic [63:0]  mw_addr;
  logic [511:0] mw_data;
  logic         reg_we;
  logic [10:0]  reg_addr;
  logic [63:0]  reg_wdata, reg_rdata;
  logic [NQ-1:0] eq_irq;

  always #4 clk = ~clk;

  msiq_router dut_i (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_is64(msi_is64),
    .msi_rid(msi_rid), .msi_len(msi_len), .msi_addr(msi_addr),
    .msi_data0(msi_data0), .msi_data1(msi_data1), .mw_valid(mw_valid),
    .mw_addr(mw_addr), .mw_data(mw_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eq_irq(eq_irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  string phase = "R1";

  bit       mv [NM];
  bit       mi [NM];
  int       mq [NM];
  int       st [NQ];
  int       hd [NQ];
  int       tl [NQ];
  bit       ov [NQ];

  task automatic check(string what, logic [511:0] act, logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  function automatic logic [63:0] model_read(logic [10:0] a);
    int k = a[10:8];
    int i = a[7:0];
    logic [63:0] r = 64'd0;
    if (k == 0 && i < NM) r = (64'(mv[i]) << 63) | (64'(mi[i]) << 62) | 64'(mq[i]);
    if (k == 4 && i < NQ) r = 64'(st[i]);
    if (k == 5 && i < NQ) r = (64'(ov[i]) << 57) | 64'(tl[i]);
    if (k == 6 && i < NQ) r = 64'(hd[i]);
    return r;
  endfunction

  function automatic logic [NQ-1:0] model_irq();
    logic [NQ-1:0] v = '0;
    for (int q = 0; q < NQ; q++) v[q] = (st[q] == 2) && (hd[q] != tl[q]);
    return v;
  endfunction

  task automatic step();
    logic          ev = 1'b0;
    logic [63:0]   ea = '0;
    logic [511:0]  ed = '0;
    if (msi_valid) begin
      int n = msi_data0;
      if (n < NM && mv[n] && !mi[n] && mq[n] < NQ && st[mq[n]] == 2) begin
        int q = mq[n];
        if ((tl[q] + 1) % 128 == hd[q]) begin
          ov[q] = 1'b1;
          st[q] = 4;
        end else begin
          logic [63:0] w0, w1;
          ev = 1'b1;
          ea = BASE + 64'(q) * 64'h10_0000 + 64'(tl[q]) * 64'd8192;
          w0 = (64'(msi_is64 ? 4'hF : 4'hB) << 59) | (64'(msi_len) << 46)
             | (64'(msi_addr[15:2]) << 32) | (64'(msi_rid) << 16) | 64'(msi_data0);
          w1 = ((msi_addr >> 16) << 16) | 64'(msi_data1);
          ed = 512'(w0) | (512'(w1) << 64);
          mi[n] = 1'b1;
          tl[q] = (tl[q] + 1) % 128;
        end
      end
    end
    if (reg_we) begin
      int k = reg_addr[10:8];
      int i = reg_addr[7:0];
      if (k == 0 && i < NM) begin
        mv[i] = reg_wdata[63]; mi[i] = reg_wdata[62]; mq[i] = reg_wdata[5:0];
      end
      if (k == 1 && i < NM && reg_wdata[62]) mi[i] = 1'b0;
      if (k == 2 && i < NQ && reg_wdata[44] && st[i] == 1) st[i] = 2;
      if (k == 3 && i < NQ) begin
        if (reg_wdata[44] && st[i] == 2) st[i] = 1;
        else if (reg_wdata[47] && st[i] == 4) st[i] = 1;
        if (reg_wdata[57]) ov[i] = 1'b0;
      end
      if (k == 5 && i < NQ) tl[i] = reg_wdata[6:0];
      if (k == 6 && i < NQ) hd[i] = reg_wdata[6:0];
    end
    @(negedge clk);
    check("mw_valid", 512'(mw_valid), 512'(ev));
    if (ev) begin
      check("mw_addr", 512'(mw_addr), 512'(ea));
      check("mw_data", mw_data, ed);
    end
    check("eq_irq", 512'(eq_irq), 512'(model_irq()));
    check("reg_rdata", 512'(reg_rdata), 512'(model_read(reg_addr)));
  endtask

  task automatic reg_wr(int kind, int idx, logic [63:0] d);
    reg_we = 1'b1; reg_addr = {3'(kind), 8'(idx)}; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_rd(int kind, int idx);
    reg_addr = {3'(kind), 8'(idx)};
    step();
  endtask

  task automatic send(int num, bit is64, logic [63:0] a, logic [15:0] d1);
    msi_valid = 1'b1; msi_is64 = is64; msi_addr = a; msi_data0 = 16'(num);
    msi_data1 = d1; msi_rid = 16'h0100 + 16'(num); msi_len = 10'(num + 1);
    step();
    msi_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NM; i++) begin mv[i] = 0; mi[i] = 0; mq[i] = 0; end
    for (int q = 0; q < NQ; q++) begin st[q] = 1; hd[q] = 0; tl[q] = 0; ov[q] = 0; end
    rst_n = 1'b0; msi_valid = 0; msi_is64 = 0; msi_rid = 0; msi_len = 0;
    msi_addr = 0; msi_data0 = 0; msi_data1 = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    check("mw_valid in reset", 512'(mw_valid), 512'(0));
    check("eq_irq in reset", 512'(eq_irq), 512'(0));
    check("map0 in reset", 512'(reg_rdata), 512'(0));
    rst_n = 1'b1;
    for (int q = 0; q < NQ; q++) reg_rd(4, q);
    reg_rd(5, 0); reg_rd(6, 0); reg_rd(0, 31);

    phase = "R2";
    reg_wr(0, 3, (64'd1 << 63) | 64'd1); reg_rd(0, 3);
    reg_wr(0, 9, (64'd1 << 63) | (64'd1 << 62) | 64'd2); reg_rd(0, 9);

    phase = "R6";
    send(3, 0, 64'hFEE0_1234, 16'h0);     // queue 1 still idle

    phase = "R10";
    reg_wr(2, 1, 64'd1 << 44); reg_rd(4, 1);

    phase = "R3 R4";
    send(3, 0, 64'h0000_0000_FEE0_1234, 16'h0);
    phase = "R5";
    reg_wr(0, 5, (64'd1 << 63) | 64'd1);
    send(5, 1, 64'h0000_1234_5678_9ABC, 16'hBEEF);

    phase = "R11";
    reg_rd(5, 1);
    phase = "R12";
    reg_wr(6, 1, 64'd2); reg_rd(6, 1);

    phase = "R7";
    send(3, 0, 64'hFEE0_0000, 16'h0);
    reg_wr(1, 3, 64'd1); reg_rd(0, 3);
    send(3, 0, 64'hFEE0_0000, 16'h0);
    reg_wr(1, 3, 64'd1 << 62); reg_rd(0, 3);
    send(3, 0, 64'hFEE0_0040, 16'h0);

    phase = "R6";
    send(9, 0, 64'hFEE0_0000, 16'h0);
    send(40, 0, 64'hFEE0_0000, 16'h0);
    reg_wr(0, 11, (64'd1 << 63) | 64'd9); send(11, 0, 64'hFEE0_0000, 16'h0);
    send(12, 0, 64'hFEE0_0000, 16'h0);
    reg_rd(5, 1);

    phase = "R8";
    reg_wr(0, 7, (64'd1 << 63) | 64'd2);
    reg_wr(2, 2, 64'd1 << 44);
    reg_wr(5, 2, 64'd126); reg_wr(6, 2, 64'd126);
    for (int r = 0; r < 3; r++) begin
      send(7, 1, 64'hABCD_0000_0000_0010 + 64'(r), 16'(r));
      reg_wr(1, 7, 64'd1 << 62);
    end
    reg_rd(5, 2);

    phase = "R9";
    reg_wr(0, 8, (64'd1 << 63) | 64'd3);
    reg_wr(2, 3, 64'd1 << 44);
    reg_wr(5, 3, 64'd126);
    send(8, 0, 64'hFEE0_0008, 16'h0);
    reg_wr(1, 8, 64'd1 << 62);
    send(8, 0, 64'hFEE0_0008, 16'h0);
    reg_rd(5, 3); reg_rd(4, 3);
    send(8, 0, 64'hFEE0_0008, 16'h0);
    reg_wr(2, 3, 64'd1 << 44); reg_rd(4, 3);

    phase = "R10";
    reg_wr(3, 3, 64'd1 << 47); reg_rd(4, 3);
    phase = "R9";
    reg_wr(3, 3, 64'd1 << 57); reg_rd(5, 3);
    phase = "R10";
    reg_wr(2, 3, 64'd1 << 44); reg_rd(4, 3);
    reg_wr(3, 3, 64'd1 << 44); reg_rd(4, 3);
    reg_wr(3, 1, 64'd1 << 44); reg_rd(4, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule